// File: doc/BRIEF.md
# Indirect Configuration Access Decoder

This block turns host I/O accesses to a pair of 4-byte ports into single configuration read or write cycles on a device-slot select bus. A host first writes a 32-bit word to the address port. The word holds an enable bit, a bus number, a device/function selector and a dword register index. The host then reads or writes the data port with a byte, word or dword access. The block combines the latched word with the low two bits of the data-port address to form the byte offset. It raises one strobe to the selected slot of 256 and forwards the access size and write data.

Read data from the selected slot arrives as the full dword of the addressed register. The block shifts it so that the addressed byte sits in the least significant lane, then masks it to the access size. Accesses that cannot be served are dropped. A read that is dropped returns all ones in the lanes of its size. This covers a cleared enable bit, a latched word whose two low bits are not zero, a bus number other than zero, or an absent slot.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset no strobe or read-valid is active and the latched address word reads back as zero.
- R2: A dword write to the address port (I/O 0xCF8..0xCFB) latches all 32 bits, and a later dword read of that port returns the latched word.
- R3: Byte or word writes to the address port leave the latched word unchanged. Byte or word reads of the address port return all ones in the lanes of the size.
- R4: While latched bit 31 is clear, data-port accesses (I/O 0xCFC..0xCFF) raise no strobe, and a read returns all ones of its size.
- R5: While latched bits [1:0] are not 00, data-port accesses raise no strobe, and a read returns all ones of its size.
- R6: While latched bits [23:16] are not zero, data-port accesses raise no strobe, and a read returns all ones of its size.
- R7: A served data-port access raises exactly one of the read or write strobe, for the cycle after the request. The device/function output equals latched bits [15:8], and the slot select vector has exactly that bit set. With no strobe active, the select vector is zero.
- R8: The forwarded offset is latched bits [7:2] followed by data-port address bits [1:0]. The forwarded size is the host size, coded 0 byte, 1 word, 2 dword, with code 3 treated as dword. The write data passes through unchanged.
- R9: Read data is valid for one cycle, two cycles after the read request. For a served read it equals the slot's dword shifted right by 8 times offset bits [1:0], masked to the size: 0xFF, 0xFFFF or all 32 bits.
- R10: A served read of a slot that reports itself absent during the strobe cycle returns all ones of its size.
- R11: Accesses to any I/O address outside the two ports raise no strobe and no read-valid, and leave the latched word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | Host access request, one cycle |
| host_write | input | 1 | 1 write, 0 read |
| host_addr | input | 16 | Host I/O byte address |
| host_size | input | 2 | 0 byte, 1 word, 2 dword, 3 dword |
| host_wdata | input | 32 | Write data, low lanes first |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 32 | Read data, addressed byte in lane 0 |
| cfg_rd_stb | output | 1 | Configuration read strobe |
| cfg_wr_stb | output | 1 | Configuration write strobe |
| cfg_slot_sel | output | 256 | One-hot slot select, active with a strobe |
| cfg_devfn | output | 8 | Device/function number of the cycle |
| cfg_offset | output | 8 | Register byte offset of the cycle |
| cfg_size | output | 2 | Access size of the cycle |
| cfg_wdata | output | 32 | Write data of the cycle |
| cfg_rdata | input | 32 | Dword of the addressed register from the selected slot |
| cfg_present | input | 1 | Selected slot holds a device |

## Verification
A request sampled on clock edge N shows its strobe, device/function, offset, size and select outputs during the cycle after edge N. Its read data and read-valid follow one cycle later, after edge N+1. An address-port write takes effect for the data-port access that follows it, even back to back. The bench drives each request on a falling edge. It samples the cycle-generation outputs at the next falling edge, and read-valid and read data at the falling edge after that. It also confirms that read-valid is still low at the first sample.

// File: rtl/cfgd_pkg.sv
package cfgd_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_WORD  = 2'd1,
      SZ_DWORD = 2'd2,
      SZ_RSVD  = 2'd3
   } xfer_size_e;

   localparam int unsigned WORD_W = 32;

   // Code 3 is served as a full dword.
   function automatic logic [1:0] norm_size(input logic [1:0] s);
      return (s == SZ_RSVD) ? SZ_DWORD : s;
   endfunction

   // Ones in the byte lanes that an access of size s covers.
   function automatic logic [WORD_W-1:0] lane_mask(input logic [1:0] s);
      logic [WORD_W-1:0] m;
      case (s)
         SZ_BYTE: m = 32'h0000_00FF;
         SZ_WORD: m = 32'h0000_FFFF;
         default: m = 32'hFFFF_FFFF;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/cfgd_addr_reg.sv
module cfgd_addr_reg #(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] lat_q,
   output logic          fld_en,
   output logic [7:0]    fld_bus,
   output logic [7:0]    fld_devfn,
   output logic [5:0]    fld_dword,
   output logic [1:0]    fld_low
);
   localparam int unsigned EN_BIT  = DW - 1;
   localparam int unsigned BUS_LSB = 16;
   localparam int unsigned DF_LSB  = 8;
   localparam int unsigned DW_LSB  = 2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q <= '0;
      else if (wr_en) lat_q <= wdata;
   end

   assign fld_en    = lat_q[EN_BIT];
   assign fld_bus   = lat_q[BUS_LSB +: 8];
   assign fld_devfn = lat_q[DF_LSB +: 8];
   assign fld_dword = lat_q[DW_LSB +: 6];
   assign fld_low   = lat_q[1:0];
endmodule

// File: rtl/cfgd_cycle_gen.sv
module cfgd_cycle_gen #(
   parameter int unsigned NUM_SLOTS = 256,
   parameter int unsigned DW        = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 issue_rd,
   input  logic                 issue_wr,
   input  logic [7:0]           devfn,
   input  logic [7:0]           offset,
   input  logic [1:0]           size,
   input  logic [DW-1:0]        wdata,
   output logic                 rd_stb,
   output logic                 wr_stb,
   output logic [7:0]           devfn_q,
   output logic [7:0]           offset_q,
   output logic [1:0]           size_q,
   output logic [DW-1:0]        wdata_q,
   output logic [NUM_SLOTS-1:0] slot_sel
);
   logic active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_stb   <= 1'b0;
         wr_stb   <= 1'b0;
         devfn_q  <= '0;
         offset_q <= '0;
         size_q   <= '0;
         wdata_q  <= '0;
      end else begin
         rd_stb <= issue_rd;
         wr_stb <= issue_wr;
         if (issue_rd || issue_wr) begin
            devfn_q  <= devfn;
            offset_q <= offset;
            size_q   <= size;
            wdata_q  <= wdata;
         end
      end
   end

   assign active = rd_stb | wr_stb;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_sel
      assign slot_sel[s] = active && (devfn_q == 8'(s));
   end
endmodule

// File: rtl/cfgd_rd_return.sv
module cfgd_rd_return
   import cfgd_pkg::*;
#(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take_cfg,
   input  logic          take_fixed,
   input  logic [DW-1:0] fixed_val,
   input  logic [1:0]    size,
   input  logic [1:0]    lane,
   input  logic [DW-1:0] cfg_rdata,
   input  logic          cfg_present,
   output logic          rvalid,
   output logic [DW-1:0] rdata
);
   logic          s1_cfg, s1_fixed;
   logic [DW-1:0] s1_val;
   logic [1:0]    s1_size, s1_lane;
   logic [DW-1:0] aligned;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_cfg   <= 1'b0;
         s1_fixed <= 1'b0;
         s1_val   <= '0;
         s1_size  <= '0;
         s1_lane  <= '0;
      end else begin
         s1_cfg   <= take_cfg;
         s1_fixed <= take_fixed;
         if (take_cfg || take_fixed) begin
            s1_val  <= fixed_val;
            s1_size <= size;
            s1_lane <= lane;
         end
      end
   end

   assign aligned = (cfg_rdata >> {s1_lane, 3'b000}) & lane_mask(s1_size);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else begin
         rvalid <= s1_cfg | s1_fixed;
         if (s1_cfg)
            rdata <= cfg_present ? aligned : lane_mask(s1_size);
         else if (s1_fixed)
            rdata <= s1_val;
      end
   end
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
   import cfgd_pkg::*;
#(
   parameter int unsigned     IO_AW      = 16,
   parameter int unsigned     DW         = 32,
   parameter int unsigned     NUM_SLOTS  = 256,
   parameter logic [IO_AW-1:0] APORT_BASE = 16'hCF8,
   parameter logic [IO_AW-1:0] DPORT_BASE = 16'hCFC
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_valid,
   input  logic                 host_write,
   input  logic [IO_AW-1:0]     host_addr,
   input  logic [1:0]           host_size,
   input  logic [DW-1:0]        host_wdata,
   output logic                 host_rvalid,
   output logic [DW-1:0]        host_rdata,
   output logic                 cfg_rd_stb,
   output logic                 cfg_wr_stb,
   output logic [NUM_SLOTS-1:0] cfg_slot_sel,
   output logic [7:0]           cfg_devfn,
   output logic [7:0]           cfg_offset,
   output logic [1:0]           cfg_size,
   output logic [DW-1:0]        cfg_wdata,
   input  logic [DW-1:0]        cfg_rdata,
   input  logic                 cfg_present
);
   localparam int unsigned PORT_LSB = 2;

   if (DW != WORD_W) begin : g_bad_dw
      $error("cfg_port_decoder: DW must be 32");
   end
   if (NUM_SLOTS < 1 || NUM_SLOTS > 256) begin : g_bad_slots
      $error("cfg_port_decoder: NUM_SLOTS must be 1..256");
   end
   if (APORT_BASE[1:0] != 2'b00 || DPORT_BASE[1:0] != 2'b00) begin : g_bad_base
      $error("cfg_port_decoder: port bases must be 4-byte aligned");
   end

   logic [DW-1:0] lat_q;
   logic          fld_en;
   logic [7:0]    fld_bus, fld_devfn;
   logic [5:0]    fld_dword;
   logic [1:0]    fld_low;
   logic          in_aport, in_dport, is_dword, cyc_ok, slot_ok;
   logic [1:0]    sz;
   logic          aport_wr, aport_rd, issue_rd, issue_wr, take_fixed;
   logic [DW-1:0] fixed_val;

   assign in_aport = host_addr[IO_AW-1:PORT_LSB] == APORT_BASE[IO_AW-1:PORT_LSB];
   assign in_dport = host_addr[IO_AW-1:PORT_LSB] == DPORT_BASE[IO_AW-1:PORT_LSB];
   assign sz       = norm_size(host_size);
   assign is_dword = (sz == SZ_DWORD);

   assign aport_wr = host_valid && host_write && in_aport && is_dword;
   assign aport_rd = host_valid && !host_write && in_aport;

   cfgd_addr_reg #(.DW(DW)) addr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (aport_wr),
      .wdata     (host_wdata),
      .lat_q     (lat_q),
      .fld_en    (fld_en),
      .fld_bus   (fld_bus),
      .fld_devfn (fld_devfn),
      .fld_dword (fld_dword),
      .fld_low   (fld_low)
   );

   assign slot_ok  = 9'(fld_devfn) < 9'(NUM_SLOTS);
   assign cyc_ok   = fld_en && (fld_low == 2'b00) && (fld_bus == 8'h00) && slot_ok;
   assign issue_rd = host_valid && in_dport && !host_write && cyc_ok;
   assign issue_wr = host_valid && in_dport &&  host_write && cyc_ok;

   assign take_fixed = aport_rd || (host_valid && in_dport && !host_write && !cyc_ok);
   assign fixed_val  = (aport_rd && is_dword) ? lat_q : lane_mask(sz);

   cfgd_cycle_gen #(.NUM_SLOTS(NUM_SLOTS), .DW(DW)) cyc_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue_rd (issue_rd),
      .issue_wr (issue_wr),
      .devfn    (fld_devfn),
      .offset   ({fld_dword, host_addr[1:0]}),
      .size     (sz),
      .wdata    (host_wdata),
      .rd_stb   (cfg_rd_stb),
      .wr_stb   (cfg_wr_stb),
      .devfn_q  (cfg_devfn),
      .offset_q (cfg_offset),
      .size_q   (cfg_size),
      .wdata_q  (cfg_wdata),
      .slot_sel (cfg_slot_sel)
   );

   cfgd_rd_return #(.DW(DW)) ret_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .take_cfg    (issue_rd),
      .take_fixed  (take_fixed),
      .fixed_val   (fixed_val),
      .size        (sz),
      .lane        (host_addr[1:0]),
      .cfg_rdata   (cfg_rdata),
      .cfg_present (cfg_present),
      .rvalid      (host_rvalid),
      .rdata       (host_rdata)
   );
endmodule

// File: rtl/cfgd_checker.sv
module cfgd_checker #(
   parameter int unsigned      IO_AW      = 16,
   parameter int unsigned      DW         = 32,
   parameter int unsigned      NUM_SLOTS  = 256,
   parameter logic [IO_AW-1:0] APORT_BASE = 16'hCF8,
   parameter logic [IO_AW-1:0] DPORT_BASE = 16'hCFC
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 host_valid,
   input logic                 host_write,
   input logic [IO_AW-1:0]     host_addr,
   input logic [1:0]           host_size,
   input logic                 host_rvalid,
   input logic                 cfg_rd_stb,
   input logic                 cfg_wr_stb,
   input logic [NUM_SLOTS-1:0] cfg_slot_sel,
   input logic [7:0]           cfg_offset,
   input logic [DW-1:0]        lat_q
);
   logic hit_a, hit_d, a_dw_wr;
   assign hit_a   = host_addr[IO_AW-1:2] == APORT_BASE[IO_AW-1:2];
   assign hit_d   = host_addr[IO_AW-1:2] == DPORT_BASE[IO_AW-1:2];
   assign a_dw_wr = host_valid && host_write && hit_a && host_size[1];

   p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_rd_stb && cfg_wr_stb));

   p_strobe_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd_stb || cfg_wr_stb) |-> $past(host_valid && hit_d));

   p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd_stb || cfg_wr_stb) |-> ($countones(cfg_slot_sel) == 1));

   p_sel_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_rd_stb || cfg_wr_stb) |-> (cfg_slot_sel == '0));

   p_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_valid && hit_d && !lat_q[DW-1]) |=> !(cfg_rd_stb || cfg_wr_stb));

   p_misaligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_valid && hit_d && (lat_q[1:0] != 2'b00)) |=> !(cfg_rd_stb || cfg_wr_stb));

   p_bus_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_valid && hit_d && (lat_q[23:16] != 8'h00)) |=> !(cfg_rd_stb || cfg_wr_stb));

   p_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_valid && hit_d && !host_write) |=> (cfg_rd_stb |-> (cfg_offset[7:2] == lat_q[7:2])));

   p_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      host_rvalid |-> $past(host_valid && !host_write && (hit_a || hit_d), 2));

   p_latch_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !a_dw_wr |=> $stable(lat_q));
endmodule

bind cfg_port_decoder cfgd_checker #(
   .IO_AW(IO_AW), .DW(DW), .NUM_SLOTS(NUM_SLOTS),
   .APORT_BASE(APORT_BASE), .DPORT_BASE(DPORT_BASE)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .host_valid   (host_valid),
   .host_write   (host_write),
   .host_addr    (host_addr),
   .host_size    (host_size),
   .host_rvalid  (host_rvalid),
   .cfg_rd_stb   (cfg_rd_stb),
   .cfg_wr_stb   (cfg_wr_stb),
   .cfg_slot_sel (cfg_slot_sel),
   .cfg_offset   (cfg_offset),
   .lat_q        (lat_q)
);

// File: tb/cfg_port_decoder_tb_top.sv
module cfg_port_decoder_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         host_valid = 1'b0, host_write = 1'b0;
   logic [15:0]  host_addr = '0;
   logic [1:0]   host_size = '0;
   logic [31:0]  host_wdata = '0;
   logic         host_rvalid;
   logic [31:0]  host_rdata;
   logic         cfg_rd_stb, cfg_wr_stb;
   logic [255:0] cfg_slot_sel;
   logic [7:0]   cfg_devfn, cfg_offset;
   logic [1:0]   cfg_size;
   logic [31:0]  cfg_wdata, cfg_rdata;
   logic         cfg_present;

   logic [255:0] present_map;
   logic [31:0]  exp_lat = '0;
   int           n_checks = 0, n_fail = 0;
   bit           done = 1'b0;

   always #10 clk = ~clk;

   cfg_port_decoder dut_i (
      .clk(clk), .rst_n(rst_n),
      .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
      .host_size(host_size), .host_wdata(host_wdata),
      .host_rvalid(host_rvalid), .host_rdata(host_rdata),
      .cfg_rd_stb(cfg_rd_stb), .cfg_wr_stb(cfg_wr_stb), .cfg_slot_sel(cfg_slot_sel),
      .cfg_devfn(cfg_devfn), .cfg_offset(cfg_offset), .cfg_size(cfg_size),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_present(cfg_present)
   );

   function automatic logic [31:0] slot_word(input logic [7:0] df, input logic [5:0] dw);
      return {df ^ 8'hA5, 2'b01, dw, df, ~df};
   endfunction

   assign cfg_present = present_map[cfg_devfn];
   assign cfg_rdata   = slot_word(cfg_devfn, cfg_offset[7:2]);

   function automatic logic [31:0] ones_of(input logic [1:0] s);
      return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                      input logic [255:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic access(input bit wr, input logic [15:0] addr, input logic [1:0] size,
                         input logic [31:0] wd, input string tag);
      logic [1:0]   sz;
      bit           in_a, in_d, ok, e_rd, e_wr, e_rv;
      logic [31:0]  e_data;
      logic [7:0]   df;
      sz   = (size == 2'd3) ? 2'd2 : size;
      in_a = addr[15:2] == 14'h33E;
      in_d = addr[15:2] == 14'h33F;
      ok   = exp_lat[31] && exp_lat[1:0] == 2'b00 && exp_lat[23:16] == 8'h00;
      df   = exp_lat[15:8];
      e_rd = in_d && !wr && ok;
      e_wr = in_d && wr && ok;
      e_rv = !wr && (in_a || in_d);
      if (in_a) e_data = (sz == 2'd2) ? exp_lat : ones_of(sz);
      else if (ok && present_map[df])
         e_data = (slot_word(df, exp_lat[7:2]) >> (8 * addr[1:0])) & ones_of(sz);
      else e_data = ones_of(sz);

      @(negedge clk);
      host_valid = 1'b1; host_write = wr; host_addr = addr;
      host_size = size; host_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      host_valid = 1'b0;
      chk(cfg_rd_stb == e_rd, {tag, " rd strobe"}, cfg_rd_stb, e_rd);
      chk(cfg_wr_stb == e_wr, {tag, " wr strobe"}, cfg_wr_stb, e_wr);
      chk(host_rvalid == 1'b0, {tag, " R9 rvalid early"}, host_rvalid, 0);
      if (e_rd || e_wr) begin
         chk(cfg_devfn == df, {tag, " R7 devfn"}, cfg_devfn, df);
         chk(cfg_slot_sel == (256'd1 << df), {tag, " R7 select"}, cfg_slot_sel, 256'd1 << df);
         chk(cfg_offset == {exp_lat[7:2], addr[1:0]}, {tag, " R8 offset"}, cfg_offset,
             {exp_lat[7:2], addr[1:0]});
         chk(cfg_size == sz, {tag, " R8 size"}, cfg_size, sz);
         if (e_wr) chk(cfg_wdata == wd, {tag, " R8 wdata"}, cfg_wdata, wd);
      end else
         chk(cfg_slot_sel == '0, {tag, " R7 select idle"}, cfg_slot_sel, 0);
      if (wr && in_a && sz == 2'd2) exp_lat = wd;
      @(negedge clk);
      chk(host_rvalid == e_rv, {tag, " R9 rvalid"}, host_rvalid, e_rv);
      if (e_rv) chk(host_rdata == e_data, {tag, " rdata"}, host_rdata, e_data);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'h5EED_0C0F));
      for (int i = 0; i < 256; i++) present_map[i] = ($urandom % 3) != 0;
      present_map[8'h0A] = 1'b1;
      present_map[8'h0B] = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk(cfg_rd_stb == 0 && cfg_wr_stb == 0, "R1 strobes idle", {cfg_rd_stb, cfg_wr_stb}, 0);
      chk(host_rvalid == 0, "R1 rvalid idle", host_rvalid, 0);
      rst_n = 1'b1;
      access(0, 16'hCF8, 2'd2, 0, "R1 readback");
      // R2: latch and read back
      access(1, 16'hCF8, 2'd2, 32'h8000_0A48, "R2 write");
      access(0, 16'hCF8, 2'd2, 0, "R2 readback");
      // R3: narrow address-port accesses
      access(1, 16'hCF8, 2'd0, 32'h12, "R3 byte write");
      access(1, 16'hCFA, 2'd1, 32'h3456, "R3 word write");
      access(0, 16'hCF8, 2'd2, 0, "R3 readback");
      access(0, 16'hCF8, 2'd1, 0, "R3 word read");
      // R7 R8 R9: served reads and writes on slot 0x0A, dword 0x12
      access(0, 16'hCFC, 2'd2, 0, "R9 dword read");
      access(0, 16'hCFE, 2'd0, 0, "R9 byte lane2");
      access(0, 16'hCFD, 2'd1, 0, "R9 word lane1");
      access(0, 16'hCFF, 2'd3, 0, "R8 size3 read");
      access(1, 16'hCFE, 2'd1, 32'hBEEF, "R8 word write");
      access(1, 16'hCFC, 2'd2, 32'hCAFE_F00D, "R7 dword write");
      // R10: absent slot 0x0B
      access(1, 16'hCF8, 2'd2, 32'h8000_0B10, "R10 setup");
      access(0, 16'hCFD, 2'd0, 0, "R10 absent byte");
      access(0, 16'hCFC, 2'd2, 0, "R10 absent dword");
      // R4: enable clear
      access(1, 16'hCF8, 2'd2, 32'h0000_0A08, "R4 setup");
      access(0, 16'hCFC, 2'd1, 0, "R4 read");
      access(1, 16'hCFC, 2'd2, 32'h1, "R4 write");
      // R5: misaligned latch
      access(1, 16'hCF8, 2'd2, 32'h8000_0A09, "R5 setup");
      access(0, 16'hCFC, 2'd2, 0, "R5 read");
      access(1, 16'hCFD, 2'd0, 32'h7, "R5 write");
      // R6: nonzero bus
      access(1, 16'hCF8, 2'd2, 32'h8003_0A08, "R6 setup");
      access(0, 16'hCFC, 2'd0, 0, "R6 read");
      access(1, 16'hCFC, 2'd2, 32'h9, "R6 write");
      // R11: foreign addresses
      access(1, 16'h0CF4, 2'd2, 32'h8000_0100, "R11 write");
      access(0, 16'h0D00, 2'd2, 0, "R11 read");
      access(0, 16'hCF8, 2'd2, 0, "R11 readback");
      // Mixed random traffic
      for (int k = 0; k < 400; k++) begin
         case ($urandom % 6)
            0: begin
               v = $urandom;
               v[31] = ($urandom % 4) != 0;
               if ($urandom % 6 != 0) v[1:0] = 2'b00;
               if ($urandom % 5 != 0) v[23:16] = 8'h00;
               access(1, 16'hCF8, 2'd2, v, "R2 rand latch");
            end
            1: access(0, 16'hCF8 | 16'($urandom % 4), 2'($urandom), 0, "R3 rand aport");
            2: access(1, 16'hCFC | 16'($urandom % 4), 2'($urandom), $urandom, "R8 rand write");
            3: access(0, 16'($urandom), 2'($urandom), 0, "R11 rand foreign");
            default: access(0, 16'hCFC | 16'($urandom % 4), 2'($urandom), 0, "R9 rand read");
         endcase
      end
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule